// File: doc/BRIEF.md
# PWM Fine Delay Stage

This block sits between a coarse pulse-width generator and an output pin and adds timing resolution finer than the coarse generator's own clock. A coarse PWM bit and a small delay code arrive from a slower control domain. The PWM bit is captured by one flip-flop in a fast clock domain. It then runs down a chain of fast-clock flip-flops, so each tap of the chain lags the previous one by exactly one fast period. A multiplexer picks one tap according to the delay code. Each edge of the coarse waveform can therefore be moved later by 0 to TAPS-1 fast periods, and those extra steps sit below the coarse period.

The delay code is not applied directly. It is first staged, and it only becomes the live selector while every tap of the chain carries the same level. At that moment the multiplexer output does not depend on which tap is chosen, so a switch cannot cut an edge that is travelling down the chain, and it cannot show the same edge twice. When the chain holds mixed levels, the previous code stays live. An optional output flip-flop after the multiplexer evens out the path to the pin and adds one fixed cycle.

Top module: `pwm_fine_delay`

## Requirements
- R1: The coarse input is captured by one fast-clock flip-flop, and the captured value is tap 0 of the delay chain.
- R2: Each tap k (k >= 1) repeats tap k-1 one fast-clock cycle later, so an edge reaches tap k exactly k cycles after tap 0.
- R3: With a constant live code c and OUT_REG = 0, a rising or falling input edge driven between clock edges appears at the output 1 + c fast cycles later, for every c from 0 to TAPS-1. The pulse width is kept, down to a one-cycle pulse.
- R4: A live-code update happens only after a cycle in which all TAPS taps are equal (all 0 or all 1). While the taps differ, the previous live code stays, even if the code input changes.
- R5: The code input is staged by one flip-flop. The staged value becomes live on the clock edge that ends the first uniform cycle after it was staged. A pulse whose rising edge leaves under code a and whose falling edge leaves under code b is lengthened by exactly b - a cycles, and the output makes exactly one rising transition for it.
- R6: A synchronous active-high reset clears the capture flop, every tap, the staged code and the live code to 0. The output is low while reset is high. After release, the first edge leaves with code 0 until a uniform cycle commits the staged code.
- R7: With OUT_REG = 1, every output edge comes exactly one cycle later than with OUT_REG = 0, so the total latency is 2 + c.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; the delay chain advances on every rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Coarse PWM bit from the slower control domain |
| dly_code | input | CW = log2(TAPS) | Requested extra delay in fast cycles (0 to TAPS-1) |
| pwm_out | output | 1 | Delayed PWM bit towards the pin |

## Verification
The hardest case to reach from the ports is a code change that arrives while an edge is still travelling down the chain. The change has to be seen to be deferred, and then applied on exactly the right cycle. The stimulus raises the input, changes the code two or three cycles later while the chain is only partly filled, and measures the rising edge under the old code and the falling edge under the new one. The rising-edge count proves that no edge was lost or repeated. A pulse shorter than the chain is also used, because it keeps the chain mixed for its whole transit, so a code change during it must wait until the chain drains to all zeros.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  localparam int unsigned LINE_MAX = 64;

  // True when bits 0..n-1 of v all carry the level of bit 0.
  function automatic logic line_is_flat(input logic [LINE_MAX-1:0] v, input int unsigned n);
    logic flat;
    flat = 1'b1;
    for (int unsigned i = 1; i < LINE_MAX; i++) begin
      if (i < n && v[i] != v[0]) flat = 1'b0;
    end
    return flat;
  endfunction

  // Cycles from an input edge to the output: capture flop, chosen taps, optional out flop.
  function automatic int unsigned path_latency(input int unsigned code, input bit out_reg);
    return 1 + code + (out_reg ? 1 : 0);
  endfunction

  // Picks one tap of a chain of width LINE_MAX.
  function automatic logic pick_tap(input logic [LINE_MAX-1:0] v, input int unsigned sel);
    return v[sel];
  endfunction

endpackage

// File: rtl/pfd_resync.sv
module pfd_resync (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end
endmodule

// File: rtl/pfd_tap_line.sv
module pfd_tap_line #(
  parameter int unsigned TAPS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            din,
  output logic [TAPS-1:0] taps,
  output logic            uniform
);
  logic [TAPS-2:0] dly;

  assign taps = {dly, din};

  always_ff @(posedge clk) begin
    if (rst) dly <= '0;
    else     dly <= taps[TAPS-2:0];
  end

  assign uniform = pfd_pkg::line_is_flat(pfd_pkg::LINE_MAX'(taps), TAPS);

  for (genvar k = 1; k < TAPS; k++) begin : g_step_chk
    // R2: a rising level at one tap shows at the next tap one cycle later
    p_edge_moves_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(taps[k-1]) |=> $rose(taps[k]));
  end
endmodule

// File: rtl/pfd_code_gate.sv
module pfd_code_gate #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] code_in,
  input  logic          uniform,
  output logic [CW-1:0] live
);
  logic [CW-1:0] staged;

  always_ff @(posedge clk) begin
    if (rst) begin
      staged <= '0;
      live   <= '0;
    end else begin
      staged <= code_in;
      if (uniform) live <= staged;
    end
  end

  // R4: a mixed chain keeps the live selector unchanged
  p_hold_mixed_r4: assert property (@(posedge clk) disable iff (rst)
    !uniform |=> $stable(live));

  // R5: after a uniform cycle the live selector equals the port value from two cycles back
  p_commit_port_r5: assert property (@(posedge clk) disable iff (rst)
    (uniform && !$past(rst)) |=> (live == $past(code_in, 2)));
endmodule

// File: rtl/pfd_tap_pick.sv
module pfd_tap_pick #(
  parameter int unsigned TAPS    = 8,
  parameter int unsigned CW      = 3,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TAPS-1:0] taps,
  input  logic [CW-1:0]   sel,
  output logic            dout
);
  logic picked;

  assign picked = pfd_pkg::pick_tap(pfd_pkg::LINE_MAX'(taps), sel);

  if (OUT_REG) begin : g_reg
    logic q;
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= picked;
    end
    assign dout = q;
  end else begin : g_comb
    assign dout = picked;
  end
endmodule

// File: rtl/pwm_fine_delay.sv
module pwm_fine_delay #(
  parameter int unsigned TAPS    = 8,
  parameter bit          OUT_REG = 1'b1,
  parameter int unsigned CW      = $clog2(TAPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwm_in,
  input  logic [CW-1:0] dly_code,
  output logic          pwm_out
);
  logic            pwm_cap;
  logic [TAPS-1:0] tap_bus;
  logic            chain_flat;
  logic [CW-1:0]   code_live;
  logic            pick_out;

  pfd_resync u_cap (
    .clk (clk),
    .rst (rst),
    .d   (pwm_in),
    .q   (pwm_cap)
  );

  pfd_tap_line #(.TAPS(TAPS)) u_line (
    .clk     (clk),
    .rst     (rst),
    .din     (pwm_cap),
    .taps    (tap_bus),
    .uniform (chain_flat)
  );

  pfd_code_gate #(.CW(CW)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .code_in (dly_code),
    .uniform (chain_flat),
    .live    (code_live)
  );

  pfd_tap_pick #(.TAPS(TAPS), .CW(CW), .OUT_REG(OUT_REG)) u_pick (
    .clk  (clk),
    .rst  (rst),
    .taps (tap_bus),
    .sel  (code_live),
    .dout (pick_out)
  );

  assign pwm_out = pick_out & ~rst;

  // R1: tap 0 is the port value captured on the previous edge
  p_capture_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (tap_bus[0] == $past(pwm_in)));

  // R6: a reset cycle leaves the chain and the live code at zero
  p_reset_clear_r6: assert property (@(posedge clk)
    rst |=> (tap_bus == '0 && code_live == '0));

  // R6: the pin stays low during reset
  p_reset_low_r6: assert property (@(posedge clk) rst |-> !pwm_out);
endmodule

// File: tb/tb_pwm_fine_delay.sv
module tb_pwm_fine_delay;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 8;
  localparam int CW = 3;
  localparam int NVEC = 8;
  // each row: code, pulse width in cycles
  localparam int VEC [NVEC][2] = '{
    '{0, 12}, '{3, 9}, '{7, 14}, '{1, 1},
    '{5, 2},  '{2, 16}, '{6, 11}, '{4, 8}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwm_in = 1'b1;
  logic [CW-1:0] code_in = 3'd5;
  logic out_r, out_c;
  int n_tests = 0;
  int n_fail = 0;
  int rises_r, rises_c;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_fine_delay #(.TAPS(TAPS), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .dly_code(code_in), .pwm_out(out_r));

  pwm_fine_delay #(.TAPS(TAPS), .OUT_REG(1'b0)) dut_comb (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .dly_code(code_in), .pwm_out(out_c));

  function automatic int exp_edge(int drive_step, int code, int reg_on);
    return drive_step + 1 + code + reg_on;
  endfunction

  task automatic check_int(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(int c);
    code_in = CW'(c);
    pwm_in = 1'b0;
    repeat (2*TAPS + 4) @(negedge clk);
  endtask

  // Drives a pulse of w cycles from step 0; records output edge steps for both instances.
  task automatic pulse(input int w, input int c2, input int chg, input bit rel,
                       output int rr, output int fr, output int rc, output int fc);
    logic pr, pc;
    rr = -1; fr = -1; rc = -1; fc = -1;
    rises_r = 0; rises_c = 0;
    pr = 1'b0; pc = 1'b0;
    for (int n = 0; n <= w + 2*TAPS + 6; n++) begin
      @(negedge clk);
      if (n > 0) begin
        if (out_r && !pr) rises_r++;
        if (out_c && !pc) rises_c++;
        if (out_r && rr < 0) rr = n;
        if (!out_r && rr >= 0 && fr < 0) fr = n;
        if (out_c && rc < 0) rc = n;
        if (!out_c && rc >= 0 && fc < 0) fc = n;
        pr = out_r; pc = out_c;
      end
      if (n == 0 && rel) rst = 1'b0;
      pwm_in = (n < w);
      if (n == chg) code_in = CW'(c2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R3 actual=timeout expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int rr, fr, rc, fc;
    // R6: in reset with the input high, both pins stay low
    repeat (4) @(negedge clk);
    check_int("R6 reg pin low in reset", int'(out_r), 0);
    check_int("R6 comb pin low in reset", int'(out_c), 0);

    // R6: release with code 5 requested; first edge leaves with code 0, fall with 5
    pulse(20, 0, -1, 1'b1, rr, fr, rc, fc);
    check_int("R6 comb rise after release", rc, exp_edge(0, 0, 0));
    check_int("R6 reg rise after release", rr, exp_edge(0, 0, 1));
    check_int("R5 comb fall after commit", fc, exp_edge(20, 5, 0));
    check_int("R5 reg fall after commit", fr, exp_edge(20, 5, 1));

    // R3 / R7: table of codes and widths
    for (int i = 0; i < NVEC; i++) begin
      settle(VEC[i][0]);
      pulse(VEC[i][1], VEC[i][0], -1, 1'b0, rr, fr, rc, fc);
      check_int($sformatf("R3 comb rise code=%0d", VEC[i][0]), rc, exp_edge(0, VEC[i][0], 0));
      check_int($sformatf("R3 comb fall code=%0d", VEC[i][0]), fc, exp_edge(VEC[i][1], VEC[i][0], 0));
      check_int($sformatf("R7 reg rise code=%0d", VEC[i][0]), rr, exp_edge(0, VEC[i][0], 1));
      check_int($sformatf("R7 reg fall code=%0d", VEC[i][0]), fr, exp_edge(VEC[i][1], VEC[i][0], 1));
    end

    // R2 / R3: one-cycle pulse through the last tap
    settle(7);
    pulse(1, 7, -1, 1'b0, rr, fr, rc, fc);
    check_int("R2 comb one-cycle width at tap 7", fc - rc, 1);
    check_int("R2 comb one-cycle rise at tap 7", rc, exp_edge(0, 7, 0));

    // R5: code 5 -> 0 while chain fills; pulse shortened by exactly 5
    settle(5);
    pulse(20, 0, 2, 1'b0, rr, fr, rc, fc);
    check_int("R4 comb rise keeps old code 5", rc, exp_edge(0, 5, 0));
    check_int("R5 comb fall uses new code 0", fc, exp_edge(20, 0, 0));
    check_int("R5 reg width 5->0", fr - rr, 20 - 5);
    check_int("R5 comb single rise 5->0", rises_c, 1);
    check_int("R5 reg single rise 5->0", rises_r, 1);

    // R5: code 1 -> 6 while chain fills; pulse lengthened by exactly 5
    settle(1);
    pulse(20, 6, 3, 1'b0, rr, fr, rc, fc);
    check_int("R4 reg rise keeps old code 1", rr, exp_edge(0, 1, 1));
    check_int("R5 reg fall uses new code 6", fr, exp_edge(20, 6, 1));
    check_int("R5 comb width 1->6", fc - rc, 20 + 5);
    check_int("R5 comb single rise 1->6", rises_c, 1);

    // R4: pulse shorter than the chain; code change must wait for the chain to drain
    settle(2);
    pulse(3, 7, 1, 1'b0, rr, fr, rc, fc);
    check_int("R4 comb rise short pulse code 2", rc, exp_edge(0, 2, 0));
    check_int("R4 comb fall short pulse code 2", fc, exp_edge(3, 2, 0));
    check_int("R4 reg fall short pulse code 2", fr, exp_edge(3, 2, 1));
    check_int("R4 reg single rise short pulse", rises_r, 1);

    // R4: after draining, code 7 is live
    pulse(4, 7, -1, 1'b0, rr, fr, rc, fc);
    check_int("R4 comb rise after drain code 7", rc, exp_edge(0, 7, 0));

    // R6: reset mid-pulse forces the pins low
    settle(0);
    pwm_in = 1'b1;
    repeat (TAPS + 2) @(negedge clk);
    check_int("R3 comb high before reset", int'(out_c), 1);
    rst = 1'b1;
    #1;
    check_int("R6 comb low on reset assert", int'(out_c), 0);
    check_int("R6 reg low on reset assert", int'(out_r), 0);
    @(negedge clk);
    check_int("R6 reg low one cycle into reset", int'(out_r), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule